// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block is a hardware controller that changes the divider setting of an analog PLL safely. It holds the PLL's control bits (lock-select, active-low reset, bypass) and its divider word, and steps them in a fixed order whenever a request arrives. A request carries a feedback multiplier m, a pre-divider p, a post-divider power s and, on the fractional variant, a signed 16-bit fraction k. If m and p already match the loaded values, only the post-divider (and fraction) is written, and the PLL keeps running. Otherwise the PLL is held in reset behind bypass, the new dividers are loaded, a settle interval is timed, reset is released and the lock input is polled against a deadline before the output leaves bypass.

The same controller also powers the PLL up (release reset behind bypass, wait for lock, leave bypass) and down (assert reset). A single request/acknowledge handshake feeds it: a request is taken only while the sequencer is idle, and each request ends in exactly one done pulse or one timeout pulse. The settle time and the lock deadline are given in microseconds and converted to cycle counts from the clock-rate parameter.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the control word is zero apart from bit 31, the divider word and fraction word are zero, reqReady is 1 and busy, done and timeoutErr are 0.
- R2: A request is taken only in a cycle where reqReady is 1; reqValid asserted while busy has no effect on any output and produces no extra completion.
- R3: A rate request (reqOp 0) whose m and p equal the loaded ones writes only s into divider bits 2:0 (and k on the fractional variant), leaves control bits 9 and 4 untouched, and raises done on the second rising edge after acceptance.
- R4: A rate request that changes m or p first sets lock-select (bit 29, integer variant only), then clears the reset bit (bit 9), then sets bypass (bit 4), then loads m into bits 21:12, p into bits 9:4 and s into bits 2:0, each on its own successive edge.
- R5: The reset bit is set again no sooner than SETTLE_US times CLK_FREQ_MHZ cycles after the dividers were loaded.
- R6: After reset is released, bypass is cleared on the second rising edge after pllLocked rises and done follows; a lock seen on the last cycle of the deadline still counts as success.
- R7: If pllLocked stays low for LOCK_TIMEOUT_US times CLK_FREQ_MHZ cycles after reset release, timeoutErr pulses exactly that many cycles after release, and bypass and the reset bit stay 1.
- R8: A power-up request (reqOp 1) while the reset bit is already 1 raises done on the first rising edge after acceptance and changes nothing.
- R9: A power-up request while the reset bit is 0 sets bypass, releases reset on the next edge, waits for lock, then clears bypass; the divider word is unchanged.
- R10: A power-down request (reqOp 2) clears the reset bit only and raises done.
- R11: busy is 1 and reqReady is 0 from the cycle after acceptance up to and including the cycle done or timeoutErr is 1.
- R12: On the integer variant (FRACTIONAL 0) the fraction word stays 0; on the fractional variant lock-select is never set and the fraction word takes k.
- R13: Control word bit 31 always shows the level of pllLocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 rate change, 1 power-up, 2 power-down, 3 no-op |
| reqM | input | 10 | Requested feedback multiplier |
| reqP | input | 6 | Requested pre-divider |
| reqS | input | 3 | Requested post-divider power |
| reqK | input | 16 | Requested two's-complement fraction |
| pllLocked | input | 1 | Lock indication from the PLL |
| reqReady | output | 1 | Sequencer idle, request will be taken |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: request completed |
| timeoutErr | output | 1 | One-cycle pulse: lock deadline missed |
| ctrlWord | output | 32 | Control word: 31 lock, 29 lock-select, 9 reset (active low), 4 bypass |
| divWord | output | 32 | Divider word: m 21:12, p 9:4, s 2:0 |
| fracWord | output | 16 | Fraction word k |

## Verification
The lock wait can see the lock input and the deadline expire on the same edge; the sequencer must give lock priority. The bench sets the PLL model's lock delay so that lock is first visible exactly on the final deadline cycle and expects a clean done with bypass cleared, then sets it one cycle later and expects timeoutErr exactly the deadline count after reset release. A second collision, a request arriving while busy, is provoked by holding reqValid high during a full sequence and judged by the divider word and the absence of any extra completion.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int M_W = 10;
  localparam int P_W = 6;
  localparam int S_W = 3;
  localparam int K_W = 16;

  // control word bit positions
  localparam int CW_LOCK = 31;
  localparam int CW_LSEL = 29;
  localparam int CW_RSTN = 9;
  localparam int CW_BYP  = 4;

  // divider word field bases
  localparam int DW_M = 12;
  localparam int DW_P = 4;
  localparam int DW_S = 0;

  localparam logic [1:0] OP_RATE = 2'd0;
  localparam logic [1:0] OP_UP   = 2'd1;
  localparam logic [1:0] OP_DOWN = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_FAST, S_LSEL, S_RSTLOW, S_BYPON, S_LOAD, S_SETTLE,
    S_RELEASE, S_WAIT, S_BYPOFF, S_DOWN, S_FINISH, S_FAIL
  } seq_state_e;

  typedef struct packed {
    logic latchReq;
    logic setLockSel;
    logic clrRst;
    logic setRst;
    logic setByp;
    logic clrByp;
    logic loadAll;
    logic loadFast;
  } strobe_t;

endpackage

// File: rtl/pllseq_regs.sv
module pllseq_regs
  import pllseq_pkg::*;
#(
  parameter bit FRACTIONAL = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  strobe_t        st,
  input  logic [M_W-1:0] reqM,
  input  logic [P_W-1:0] reqP,
  input  logic [S_W-1:0] reqS,
  input  logic [K_W-1:0] reqK,
  input  logic           pllLocked,
  output logic           mpMatch,
  output logic           rstReleased,
  output logic [31:0]    ctrlWord,
  output logic [31:0]    divWord,
  output logic [15:0]    fracWord
);

  logic           lockSel, rstN, byp;
  logic [M_W-1:0] mCur, mPend;
  logic [P_W-1:0] pCur, pPend;
  logic [S_W-1:0] sCur, sPend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockSel <= 1'b0;
      rstN    <= 1'b0;
      byp     <= 1'b0;
    end else begin
      if (st.setLockSel) lockSel <= 1'b1;
      if (st.clrRst)     rstN    <= 1'b0;
      if (st.setRst)     rstN    <= 1'b1;
      if (st.setByp)     byp     <= 1'b1;
      if (st.clrByp)     byp     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCur  <= '0;
      pCur  <= '0;
      sCur  <= '0;
      mPend <= '0;
      pPend <= '0;
      sPend <= '0;
    end else begin
      if (st.latchReq) begin
        mPend <= reqM;
        pPend <= reqP;
        sPend <= reqS;
      end
      if (st.loadAll) begin
        mCur <= mPend;
        pCur <= pPend;
      end
      if (st.loadAll || st.loadFast) sCur <= sPend;
    end
  end

  generate
    if (FRACTIONAL) begin : g_frac
      logic [K_W-1:0] kPend, kCur;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          kPend <= '0;
          kCur  <= '0;
        end else begin
          if (st.latchReq) kPend <= reqK;
          if (st.loadAll || st.loadFast) kCur <= kPend;
        end
      end
      assign fracWord = kCur;
    end else begin : g_int
      logic unusedK;
      assign unusedK  = ^reqK;
      assign fracWord = '0;
    end
  endgenerate

  assign mpMatch     = (reqM == mCur) && (reqP == pCur);
  assign rstReleased = rstN;

  always_comb begin
    ctrlWord          = '0;
    ctrlWord[CW_LOCK] = pllLocked;
    ctrlWord[CW_LSEL] = lockSel;
    ctrlWord[CW_RSTN] = rstN;
    ctrlWord[CW_BYP]  = byp;
    divWord                   = '0;
    divWord[DW_M +: M_W]      = mCur;
    divWord[DW_P +: P_W]      = pCur;
    divWord[DW_S +: S_W]      = sCur;
  end

  // R9: reset is only ever released with the output bypassed
  p_release_bypassed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstN) |-> byp);

  // R3: a post-divider-only update never touches reset or bypass
  p_fast_keeps_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadFast |=> ($stable(rstN) && $stable(byp)));

  // R6: bypass drops only after the lock input was seen
  p_bypass_drop_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byp) |-> $past(pllLocked));

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter bit FRACTIONAL  = 1'b0,
  parameter int SETTLE_CYC  = 750,
  parameter int TIMEOUT_CYC = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       mpMatch,
  input  logic       rstReleased,
  input  logic       pllLocked,
  output strobe_t    st,
  output logic       reqReady,
  output logic       busy,
  output logic       done,
  output logic       timeoutErr
);

  localparam int CNT_MAX = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam seq_state_e FULL_START = FRACTIONAL ? S_RSTLOW : S_LSEL;

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             upOnly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      upOnly <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          upOnly <= 1'b0;
          cnt    <= '0;
          case (reqOp)
            OP_RATE: state <= mpMatch ? S_FAST : FULL_START;
            OP_UP: begin
              if (rstReleased) state <= S_FINISH;
              else begin
                state  <= S_BYPON;
                upOnly <= 1'b1;
              end
            end
            OP_DOWN: state <= S_DOWN;
            default: state <= S_FINISH;
          endcase
        end
        S_FAST, S_DOWN, S_BYPOFF: state <= S_FINISH;
        S_LSEL:   state <= S_RSTLOW;
        S_RSTLOW: state <= S_BYPON;
        S_BYPON:  state <= upOnly ? S_RELEASE : S_LOAD;
        S_LOAD: begin
          state <= S_SETTLE;
          cnt   <= '0;
        end
        S_SETTLE: begin
          if (cnt == SETTLE_LAST) state <= S_RELEASE;
          else cnt <= cnt + 1'b1;
        end
        S_RELEASE: begin
          state <= S_WAIT;
          cnt   <= '0;
        end
        S_WAIT: begin
          if (pllLocked) state <= S_BYPOFF;
          else if (cnt == TIMEOUT_LAST) state <= S_FAIL;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st            = '0;
    st.latchReq   = (state == S_IDLE) && reqValid;
    st.loadFast   = (state == S_FAST);
    st.setLockSel = (state == S_LSEL);
    st.clrRst     = (state == S_RSTLOW) || (state == S_DOWN);
    st.setByp     = (state == S_BYPON);
    st.loadAll    = (state == S_LOAD);
    st.setRst     = (state == S_RELEASE);
    st.clrByp     = (state == S_BYPOFF);
  end

  assign reqReady   = (state == S_IDLE);
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FINISH);
  assign timeoutErr = (state == S_FAIL);

  // R7: a failure follows only an unlocked final wait cycle
  p_fail_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FAIL) |-> ($past(state) == S_WAIT && !$past(pllLocked)));

  // R5: a full-sequence release always follows the settle interval
  p_release_after_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RELEASE && !upOnly) |-> ($past(state) == S_SETTLE));

  // R2: a request seen while busy leaves the latch strobe low
  p_no_latch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && busy) |-> !st.latchReq);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pllseq_pkg::*;
#(
  parameter int CLK_FREQ_MHZ    = 250,
  parameter int SETTLE_US       = 3,
  parameter int LOCK_TIMEOUT_US = 10000,
  parameter bit FRACTIONAL      = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [9:0]  reqM,
  input  logic [5:0]  reqP,
  input  logic [2:0]  reqS,
  input  logic [15:0] reqK,
  input  logic        pllLocked,
  output logic        reqReady,
  output logic        busy,
  output logic        done,
  output logic        timeoutErr,
  output logic [31:0] ctrlWord,
  output logic [31:0] divWord,
  output logic [15:0] fracWord
);

  localparam int SETTLE_CYC  = SETTLE_US * CLK_FREQ_MHZ;
  localparam int TIMEOUT_CYC = LOCK_TIMEOUT_US * CLK_FREQ_MHZ;

  strobe_t st;
  logic    mpMatch, rstReleased;

  pllseq_ctrl #(
    .FRACTIONAL(FRACTIONAL), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .mpMatch(mpMatch), .rstReleased(rstReleased), .pllLocked(pllLocked),
    .st(st), .reqReady(reqReady), .busy(busy), .done(done),
    .timeoutErr(timeoutErr)
  );

  pllseq_regs #(.FRACTIONAL(FRACTIONAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .st(st), .reqM(reqM), .reqP(reqP),
    .reqS(reqS), .reqK(reqK), .pllLocked(pllLocked), .mpMatch(mpMatch),
    .rstReleased(rstReleased), .ctrlWord(ctrlWord), .divWord(divWord),
    .fracWord(fracWord)
  );

endmodule

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;

  localparam int MHZ      = 250;
  localparam int TO_US    = 20;
  localparam int SETTLE_C = 3 * MHZ;
  localparam int TO_C     = TO_US * MHZ;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [9:0]  reqM = '0;
  logic [5:0]  reqP = '0;
  logic [2:0]  reqS = '0;
  logic [15:0] reqK = '0;

  logic        lockA, lockB;
  logic        rdyA, busyA, doneA, errA, rdyB, busyB, doneB, errB;
  logic [31:0] ctrlA, divA, ctrlB, divB;
  logic [15:0] fracA, fracB;

  pll_reprog_seq #(.CLK_FREQ_MHZ(MHZ), .LOCK_TIMEOUT_US(TO_US), .FRACTIONAL(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqM(reqM),
    .reqP(reqP), .reqS(reqS), .reqK(reqK), .pllLocked(lockA), .reqReady(rdyA),
    .busy(busyA), .done(doneA), .timeoutErr(errA), .ctrlWord(ctrlA),
    .divWord(divA), .fracWord(fracA));

  pll_reprog_seq #(.CLK_FREQ_MHZ(MHZ), .LOCK_TIMEOUT_US(TO_US), .FRACTIONAL(1'b1)) dutFrac (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqM(reqM),
    .reqP(reqP), .reqS(reqS), .reqK(reqK), .pllLocked(lockB), .reqReady(rdyB),
    .busy(busyB), .done(doneB), .timeoutErr(errB), .ctrlWord(ctrlB),
    .divWord(divB), .fracWord(fracB));

  // PLL models: lock rises lockDelay+1 cycles after reset release is seen
  int lockDelay = 20;
  int cntA, cntB;
  always_ff @(posedge clk) begin
    if (!rst_n || !ctrlA[9]) begin cntA <= 0; lockA <= 1'b0; end
    else if (cntA >= lockDelay) lockA <= 1'b1;
    else cntA <= cntA + 1;
  end
  always_ff @(posedge clk) begin
    if (!rst_n || !ctrlB[9]) begin cntB <= 0; lockB <= 1'b0; end
    else if (cntB >= lockDelay) lockB <= 1'b1;
    else cntB <= cntB + 1;
  end

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // event times on the integer instance
  int tLsel, tRstFall, tRstRise, tBypRise, tBypFall, tDiv, tLock;
  logic pLsel, pRst, pByp, pLock;
  logic [31:0] pDiv;
  initial begin
    tLsel = -1; tRstFall = -1; tRstRise = -1; tBypRise = -1;
    tBypFall = -1; tDiv = -1; tLock = -1;
    pLsel = 0; pRst = 0; pByp = 0; pLock = 0; pDiv = '0;
  end
  always @(negedge clk) if (rst_n) begin
    if (ctrlA[29] && !pLsel) tLsel = cyc;
    if (!ctrlA[9] && pRst) tRstFall = cyc;
    if (ctrlA[9] && !pRst) tRstRise = cyc;
    if (ctrlA[4] && !pByp) tBypRise = cyc;
    if (!ctrlA[4] && pByp) tBypFall = cyc;
    if (lockA && !pLock) tLock = cyc;
    if (divA != pDiv) tDiv = cyc;
    pLsel = ctrlA[29]; pRst = ctrlA[9]; pByp = ctrlA[4]; pLock = lockA; pDiv = divA;
  end

  // scoreboard
  typedef struct {
    bit err; bit lsel; bit rstN; bit byp;
    logic [31:0] div; logic [15:0] frac;
  } exp_t;
  exp_t sbQ[$];

  bit mLsel = 0, mRst = 0, mByp = 0;
  logic [9:0] mM = '0; logic [5:0] mP = '0; logic [2:0] mS = '0; logic [15:0] mK = '0;

  task automatic doReq(input logic [1:0] op, input logic [9:0] m, input logic [5:0] p,
                       input logic [2:0] s, input logic [15:0] k, input bit expErr);
    exp_t e;
    @(negedge clk);
    while (!(rdyA && rdyB)) @(negedge clk);
    if (op == 2'd0) begin
      if (!(m == mM && p == mP)) begin
        mLsel = 1; mRst = 1; mByp = expErr; mM = m; mP = p;
      end
      mS = s; mK = k;
    end else if (op == 2'd1) begin
      if (!mRst) begin mRst = 1; mByp = 0; end
    end else if (op == 2'd2) begin
      mRst = 0;
    end
    e.err = expErr; e.lsel = mLsel; e.rstN = mRst; e.byp = mByp;
    e.div = {10'd0, mM, 2'd0, mP, 1'b0, mS}; e.frac = mK;
    sbQ.push_back(e);
    reqValid = 1'b1; reqOp = op; reqM = m; reqP = p; reqS = s; reqK = k;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && (doneA || errA)) begin
    exp_t e;
    if (sbQ.size() == 0) chk(0, "R2 completion without pending request", 1, 0);
    else begin
      e = sbQ.pop_front();
      chk(errA == e.err, "R7 completion kind", errA, e.err);
      chk(divA == e.div, "R4 divider word", divA, e.div);
      chk(divB == e.div, "R3 divider word fractional", divB, e.div);
      chk(ctrlA[9] == e.rstN, "R10 reset bit", ctrlA[9], e.rstN);
      chk(ctrlA[4] == e.byp, "R7 bypass bit", ctrlA[4], e.byp);
      chk(ctrlA[29] == e.lsel, "R12 lock-select integer", ctrlA[29], e.lsel);
      chk(ctrlB[29] == 1'b0, "R12 lock-select fractional", ctrlB[29], 0);
      chk(fracA == 16'd0, "R12 fraction integer", fracA, 0);
      chk(fracB == e.frac, "R12 fraction fractional", fracB, e.frac);
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (sbQ.size() != 0 || !rdyA || !rdyB) @(negedge clk);
    @(negedge clk);
  endtask

  // follow a long request to its end, checking busy; optional spam for R2
  task automatic runLong(input int spam);
    int bad = 0;
    chk(busyA && !rdyA, "R11 busy after accept", busyA, 1);
    while (!doneA && !errA) begin
      if (!busyA || rdyA) bad++;
      if (spam > 0) begin
        reqValid = 1'b1; reqOp = 2'd0; reqM = 10'd99; reqP = 6'd9; reqS = 3'd7; reqK = 16'h1234;
        spam--;
      end else reqValid = 1'b0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(busyA && bad == 0, "R11 busy held to completion", bad, 0);
    @(negedge clk);
    chk(rdyA && !busyA, "R11 ready after completion", rdyA, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrlA == 32'd0, "R1 control word", ctrlA, 0);
    chk(divA == 32'd0 && fracB == 16'd0, "R1 divider and fraction", divA, 0);
    chk(rdyA && !busyA && !doneA && !errA, "R1 handshake", {rdyA, busyA, doneA, errA}, 4'b1000);
    chk(ctrlA[31] == lockA, "R13 lock mirror low", ctrlA[31], lockA);

    // R9 power-up from down
    lockDelay = 20;
    doReq(2'd1, 0, 0, 0, 0, 0);
    runLong(0);
    waitIdle();
    chk(tRstRise == tBypRise + 1, "R9 release after bypass", tRstRise - tBypRise, 1);
    chk(tBypFall - tLock == 2, "R6 bypass drop after lock", tBypFall - tLock, 2);

    // R8 power-up while running
    doReq(2'd1, 0, 0, 0, 0, 0);
    chk(doneA == 1'b1, "R8 immediate done", doneA, 1);
    waitIdle();

    // R4 R5 R6 full sequence, with requests pushed while busy (R2)
    doReq(2'd0, 10'd200, 6'd3, 3'd0, 16'd100, 0);
    runLong(3);
    waitIdle();
    chk(tRstFall == tLsel + 1, "R4 reset after lock-select", tRstFall - tLsel, 1);
    chk(tBypRise == tRstFall + 1, "R4 bypass after reset", tBypRise - tRstFall, 1);
    chk(tDiv == tBypRise + 1, "R4 load after bypass", tDiv - tBypRise, 1);
    chk(tRstRise - tDiv >= SETTLE_C, "R5 settle interval", tRstRise - tDiv, SETTLE_C);
    chk(tBypFall - tLock == 2, "R6 bypass drop after lock", tBypFall - tLock, 2);

    // R3 post-divider and fraction only
    t0 = tRstFall;
    doReq(2'd0, 10'd200, 6'd3, 3'd2, 16'hFFFB, 0);
    chk(!doneA && busyA, "R3 not done on first cycle", doneA, 0);
    @(negedge clk);
    chk(doneA, "R3 done on second edge", doneA, 1);
    waitIdle();
    chk(tRstFall == t0 && ctrlA[9] && !ctrlA[4], "R3 reset and bypass untouched", tRstFall, t0);

    // R7 lock one cycle too late
    lockDelay = TO_C - 1;
    doReq(2'd0, 10'd250, 6'd2, 3'd1, 16'd9, 1);
    while (!errA) @(negedge clk);
    chk(cyc - tRstRise == TO_C, "R7 deadline length", cyc - tRstRise, TO_C);
    waitIdle();

    // R10 power-down
    lockDelay = 20;
    doReq(2'd2, 0, 0, 0, 0, 0);
    waitIdle();
    chk(!ctrlA[9] && ctrlA[4] && ctrlA[29], "R10 only reset cleared", ctrlA, 32'h2000_0010);

    // R9 power-up again, divider kept
    doReq(2'd1, 0, 0, 0, 0, 0);
    runLong(0);
    waitIdle();
    chk(divA == {10'd0, 10'd250, 2'd0, 6'd2, 1'b0, 3'd1}, "R9 divider unchanged", divA, 0);

    // R6 lock on the last deadline cycle wins
    lockDelay = TO_C - 2;
    doReq(2'd0, 10'd173, 6'd2, 3'd1, 16'd16384, 0);
    runLong(0);
    waitIdle();
    chk(!ctrlA[4], "R6 lock at deadline edge", ctrlA[4], 0);
    chk(ctrlA[31] == lockA && lockA, "R13 lock mirror high", ctrlA[31], 1);

    // R3 second fast update
    doReq(2'd0, 10'd173, 6'd2, 3'd3, 16'd7, 0);
    waitIdle();
    summary();
  end

endmodule